// File: doc/BRIEF.md
# Reset-Delay Sync Clock Leveling Calibrator

This block lines up several external converter channels to one reference phase. It runs on an internal reference sync clock that is phase-locked to the converters' system clock. For each channel in turn it sends a reset pulse, waits, and samples the sync clock that the channel returns. On each new attempt the pulse is launched one reference cycle later than on the attempt before. The block stops sweeping a channel at the first attempt where the sampled return has gone from low to high. The launch delay of that attempt is stored as the channel's calibration value. No time-to-digital converter is involved. Detecting an edge on the synchronized sample is the only measurement, which is the same idea as memory write leveling.

One sync period equals twenty-four system clock periods, so the delay range is set by the `NSTEPS` parameter (24 by default). A start strobe begins a full calibration pass over all channels, lowest index first. Each channel ends with either a stored delay or a fail flag. A done flag rises once the highest channel is finished.

Top module: `sync_level_cal`

## Requirements
- R1: After reset, every `chan_rst` bit, every `fail` bit, `done` and every delay field are 0.
- R2: A `start` high on a clock edge while the block is idle begins a pass at channel 0 with delay step 0. A `start` while a pass is running has no effect on pulses or results.
- R3: At most one `chan_rst` bit is high at any time. Each pulse lasts exactly one cycle. Channels are swept in ascending index order, and a channel receives no pulses after its sweep ends.
- R4: Within one channel's sweep, the pulse for step k+1 comes exactly `SETTLE`+k+3 reference cycles after the pulse for step k. The launch delay therefore grows by one cycle per step.
- R5: Each `sync_ret` bit passes through a two-stage synchronizer. It is evaluated once per step, `SETTLE` cycles after the pulse has been launched.
- R6: A rising transition means that the previous step's sample of that channel was 0 and the current step's sample is 1. Step 0 has no previous sample and never counts. On a rising transition the step index is stored in that channel's field `delay_val[ch*DW +: DW]` and the channel's sweep ends.
- R7: If step `NSTEPS`-1 is evaluated without a rising transition, `fail[ch]` is set to 1 and that channel's delay field stays 0.
- R8: `done` rises in the cycle after the last channel's sweep ends and holds until the next accepted start. An accepted start clears `done`, all `fail` bits and all delay fields on the same edge.
- R9: Every channel's sweep restarts from step 0 with no previous sample, so results do not depend on other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal reference sync clock, phase-locked to the converter system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a calibration pass when idle |
| sync_ret | input | NCH | Returned sync clock from each channel (asynchronous) |
| chan_rst | output | NCH | One-cycle reset pulse to each channel |
| delay_val | output | NCH*DW | Calibrated delay per channel, channel ch in bits [ch*DW +: DW] |
| fail | output | NCH | Channel found no rising transition within the sweep |
| done | output | 1 | Pass complete |

## Verification
The assertions check on every cycle that reset pulses are one-hot and one cycle wide and that no pulse is sent once done is set. They also check that a failed channel holds a zero delay, that the end of a sweep raises done, and that an accepted start clears the results. Only the bench scenarios can show that the launch delay grows by exactly one cycle per step and that the first low-to-high return is the one stored. The same goes for a return that is high from step 0 or that never rises ending in failure, and for a second start during a pass being ignored. The bench drives a channel model whose level depends only on how many pulses that channel has received.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_SETTLE,
    ST_EVAL
  } cal_state_e;

  // A step counts as the edge only when the prior step saw low and this one sees high.
  function automatic logic is_rise(input logic prev_s, input logic cur_s);
    return (!prev_s) && cur_s;
  endfunction

  // Spacing between successive pulses of one channel, launched at step k.
  function automatic int pulse_gap(input int settle, input int k);
    return settle + k + 3;
  endfunction

endpackage

// File: rtl/calib_sync2.sv
module calib_sync2 #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_in,
  output logic [NCH-1:0] q_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_in[g];
        s2 <= s1;
      end
    end
    assign q_out[g] = s2;
  end
endmodule

// File: rtl/calib_sweep.sv
module calib_sweep
  import calib_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NSTEPS = 24,
  parameter int SETTLE = 4,
  localparam int DW    = $clog2(NSTEPS),
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW    = $clog2(SETTLE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCH-1:0] samp,
  output logic [NCH-1:0] pulse_q,
  output logic [CW-1:0]  ch_idx,
  output logic [DW-1:0]  step,
  output logic           start_evt,
  output logic           hit_evt,
  output logic           miss_evt,
  output logic           sweep_end_evt
);
  cal_state_e     state;
  logic [DW-1:0]  cnt;
  logic [SW-1:0]  scnt;
  logic           prev_s;
  logic           cur_s;
  logic           launch_evt;
  logic           chan_end;
  logic           last_ch;

  assign cur_s         = samp[ch_idx];
  assign start_evt     = (state == ST_IDLE) && start;
  assign launch_evt    = (state == ST_LAUNCH) && (cnt == step);
  assign hit_evt       = (state == ST_EVAL) && is_rise(prev_s, cur_s);
  assign miss_evt      = (state == ST_EVAL) && !is_rise(prev_s, cur_s)
                         && (step == DW'(NSTEPS - 1));
  assign chan_end      = hit_evt || miss_evt;
  assign last_ch       = (ch_idx == CW'(NCH - 1));
  assign sweep_end_evt = chan_end && last_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ch_idx <= '0;
      step   <= '0;
      cnt    <= '0;
      scnt   <= '0;
      prev_s <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_LAUNCH;
          ch_idx <= '0;
          step   <= '0;
          cnt    <= '0;
          prev_s <= 1'b1;
        end
        ST_LAUNCH: begin
          if (cnt == step) begin
            state <= ST_SETTLE;
            scnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (scnt == SW'(SETTLE - 1)) state <= ST_EVAL;
          else                         scnt  <= scnt + 1'b1;
        end
        ST_EVAL: begin
          cnt <= '0;
          if (chan_end) begin
            if (last_ch) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_LAUNCH;
              ch_idx <= ch_idx + 1'b1;
              step   <= '0;
              prev_s <= 1'b1;
            end
          end else begin
            state  <= ST_LAUNCH;
            step   <= step + 1'b1;
            prev_s <= cur_s;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        pulse_q[i] <= launch_evt && (ch_idx == CW'(i));
    end
  end
endmodule

// File: rtl/calib_store.sv
module calib_store #(
  parameter int NCH = 4,
  parameter int DW  = 5,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              hit_evt,
  input  logic              miss_evt,
  input  logic              sweep_end_evt,
  input  logic [CW-1:0]     ch_idx,
  input  logic [DW-1:0]     step,
  output logic [NCH*DW-1:0] delay_flat,
  output logic [NCH-1:0]    fail_q,
  output logic              done_q
);
  logic [NCH-1:0][DW-1:0] dly;

  always_ff @(posedge clk) begin
    if (!rst_n || start_evt) begin
      dly    <= '0;
      fail_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (hit_evt)       dly[ch_idx]    <= step;
      if (miss_evt)      fail_q[ch_idx] <= 1'b1;
      if (sweep_end_evt) done_q         <= 1'b1;
    end
  end

  assign delay_flat = dly;
endmodule

// File: rtl/sync_level_cal.sv
module sync_level_cal #(
  parameter int NCH    = 4,
  parameter int NSTEPS = 24,
  parameter int SETTLE = 4,
  localparam int DW    = $clog2(NSTEPS),
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH-1:0]    sync_ret,
  output logic [NCH-1:0]    chan_rst,
  output logic [NCH*DW-1:0] delay_val,
  output logic [NCH-1:0]    fail,
  output logic              done
);
  logic [NCH-1:0] samp;
  logic [CW-1:0]  ch_idx;
  logic [DW-1:0]  step;
  logic           start_evt;
  logic           hit_evt;
  logic           miss_evt;
  logic           sweep_end_evt;

  calib_sync2 #(.NCH(NCH)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d_in  (sync_ret),
    .q_out (samp)
  );

  calib_sweep #(.NCH(NCH), .NSTEPS(NSTEPS), .SETTLE(SETTLE)) u_sweep (
    .clk           (clk_ref),
    .rst_n         (rst_n),
    .start         (start),
    .samp          (samp),
    .pulse_q       (chan_rst),
    .ch_idx        (ch_idx),
    .step          (step),
    .start_evt     (start_evt),
    .hit_evt       (hit_evt),
    .miss_evt      (miss_evt),
    .sweep_end_evt (sweep_end_evt)
  );

  calib_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk           (clk_ref),
    .rst_n         (rst_n),
    .start_evt     (start_evt),
    .hit_evt       (hit_evt),
    .miss_evt      (miss_evt),
    .sweep_end_evt (sweep_end_evt),
    .ch_idx        (ch_idx),
    .step          (step),
    .delay_flat    (delay_val),
    .fail_q        (fail),
    .done_q        (done)
  );
endmodule

// File: rtl/sync_level_cal_chk.sv
module sync_level_cal_chk #(
  parameter int NCH = 4,
  parameter int DW  = 5
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic [NCH-1:0]    chan_rst,
  input logic [NCH*DW-1:0] delay_val,
  input logic [NCH-1:0]    fail,
  input logic              done,
  input logic              start_evt,
  input logic              sweep_end_evt
);
  p_pulse_onehot_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $onehot0(chan_rst));

  p_pulse_single_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (chan_rst != '0) |=> (chan_rst == '0));

  p_quiet_done_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |-> (chan_rst == '0));

  p_end_done_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sweep_end_evt |=> done);

  p_start_clear_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start_evt |=> (!done && fail == '0 && delay_val == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_fail_zero_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      fail[g] |-> (delay_val[g*DW +: DW] == '0));
  end
endmodule

bind sync_level_cal sync_level_cal_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_ref       (clk_ref),
  .rst_n         (rst_n),
  .chan_rst      (chan_rst),
  .delay_val     (delay_val),
  .fail          (fail),
  .done          (done),
  .start_evt     (start_evt),
  .sweep_end_evt (sweep_end_evt)
);

// File: tb/sync_level_cal_tb.sv
module sync_level_cal_tb;
  localparam int NCH    = 4;
  localparam int NSTEPS = 24;
  localparam int SETTLE = 4;
  localparam int DW     = $clog2(NSTEPS);

  typedef struct {
    int ch;
    bit fl;
    int dly;
    int npulse;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NCH-1:0]    sync_ret;
  logic [NCH-1:0]    chan_rst;
  logic [NCH*DW-1:0] delay_val;
  logic [NCH-1:0]    fail;
  logic              done;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  thr [NCH];
  int  pcnt [NCH];
  int  last_cyc [NCH];
  bit  lvl [NCH];
  bit  clr = 1'b0;
  bit  done_prev = 1'b0;
  int  checked_runs = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  sync_level_cal #(.NCH(NCH), .NSTEPS(NSTEPS), .SETTLE(SETTLE)) u_dut (
    .clk_ref   (clk_ref_w),
    .rst_n     (rst_n),
    .start     (start),
    .sync_ret  (sync_ret),
    .chan_rst  (chan_rst),
    .delay_val (delay_val),
    .fail      (fail),
    .done      (done)
  );
  wire clk_ref_w = clk;

  always_comb for (int i = 0; i < NCH; i++) sync_ret[i] = lvl[i];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Monitor: channel model, pulse spacing, scoreboard compare at done.
  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      for (int i = 0; i < NCH; i++) begin
        pcnt[i] = 0;
        lvl[i]  = 1'b0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (chan_rst[i]) begin
          if (pcnt[i] > 0)   // R4 launch delay grows one cycle per step
            chk(cyc - last_cyc[i] == SETTLE + (pcnt[i] - 1) + 3, "R4 pulse gap",
                cyc - last_cyc[i], SETTLE + (pcnt[i] - 1) + 3);
          for (int j = i + 1; j < NCH; j++)  // R3 ascending order
            chk(pcnt[j] == 0, "R3 channel order", pcnt[j], 0);
          last_cyc[i] = cyc;
          pcnt[i]++;
          lvl[i] = (pcnt[i] > thr[i]);
        end
      end
    end
    if (done && !done_prev) begin
      for (int i = 0; i < NCH; i++) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
          break;
        end
        e = q.pop_front();
        chk(fail[e.ch] == e.fl, e.fl ? "R7 fail flag" : "R6 fail flag", fail[e.ch], e.fl);
        chk(int'(delay_val[e.ch*DW +: DW]) == e.dly, e.fl ? "R7 delay zero" : "R6 delay",
            delay_val[e.ch*DW +: DW], e.dly);
        chk(pcnt[e.ch] == e.npulse, "R9 pulse count", pcnt[e.ch], e.npulse);
      end
      checked_runs++;
    end
    done_prev = done;
  end

  // Driver: loads thresholds, pushes expectations, starts a pass.
  task automatic run_pass(input int t0, input int t1, input int t2, input int t3,
                          input bit extra_start);
    int ts [NCH];
    int w;
    ts = '{t0, t1, t2, t3};
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      exp_t e;
      thr[i] = ts[i];
      e.ch = i;
      if (ts[i] >= 1 && ts[i] <= NSTEPS - 1) begin
        e.fl = 1'b0; e.dly = ts[i]; e.npulse = ts[i] + 1;
      end else begin
        e.fl = 1'b1; e.dly = 0; e.npulse = NSTEPS;
      end
      q.push_back(e);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8 done cleared", done, 0);
    chk(fail == '0, "R8 fail cleared", fail, 0);
    if (extra_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;   // R2 ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R8 done raised", done, 1);
    repeat (3) @(negedge clk);
    chk(chan_rst == '0, "R3 no pulse after done", chan_rst, 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      thr[i] = 0; pcnt[i] = 0; lvl[i] = 1'b0; last_cyc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(chan_rst == '0, "R1 chan_rst", chan_rst, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(fail == '0, "R1 fail", fail, 0);
    chk(delay_val == '0, "R1 delay", delay_val, 0);
    // R2 start launches channel 0 first
    run_pass(3, 1, 10, 23, 1'b0);
    // R5 R6 R7 high from step 0, beyond range, and mid range
    run_pass(0, 24, 5, 30, 1'b0);
    // R2 second start during a pass is ignored; R9 independence
    run_pass(7, 0, 1, 12, 1'b1);
    // R8 results held while idle
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R8 done held", done, 1);
    chk(int'(delay_val[3*DW +: DW]) == 12, "R8 delay held", delay_val[3*DW +: DW], 12);
    chk(checked_runs == 3, "R8 pass count", checked_runs, 3);
    chk(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule